// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slow one whose average period is not a whole number of reference cycles. A typical use is making a 32.768 kHz timebase from a 24 MHz reference. Two integer divisors take turns. The first divisor is applied for a programmable number of output periods, then the second divisor for its own number of periods, and the pattern repeats. The long-run average ratio is therefore a weighted mean of the two divisors.

Two 32-bit control words carry the configuration. Word 0 holds both divisors, a mode bit that turns alternation on, and two gates: one for the counting logic and one for the visible output. Word 1 holds the two repeat counts and a bypass bit. The block drives three outputs. The first is the divided clock level. The second is a one-cycle strobe on the last reference cycle of every output period. The third is a flag that shows when the second divisor is in use.

Configuration is meant to be changed with both gates clear. Software then opens the input gate and, after a settling delay, the output gate.

Top module: `frac_clk_div`

## Requirements
- R1: Every divisor and repeat field holds its value minus one. With alternation off (word 0 bit 28 = 0), strobes are exactly N1 = word0[11:0]+1 reference cycles apart.
- R2: With alternation on (word 0 bit 28 = 1), the block produces a repeating pattern:
  - M1 = word1[11:0]+1 periods of N1 cycles;
  - then M2 = word1[23:12]+1 periods of N2 = word0[23:12]+1 cycles.
- R3: With alternation off, the N2 field, both repeat fields and all their values have no effect on the period, and `usingSecond` stays low.
- R4: `usingSecond` is high during exactly those output periods that use N2, including the cycle that carries their strobe.
- R5: Within each output period of N cycles, `divClk` is high for the first floor(N/2) cycles and low for the rest.
- R6: Setting bypass (word 1 bit 24) while the input gate is set raises the strobe on every reference cycle. In this mode `divClk` stays low and `usingSecond` stays low.
- R7: While the input gate (word 0 bit 31) is clear, the following hold:
  - all counters are held at zero;
  - `divClk`, `periodStrobe` and `usingSecond` are low.
  Setting the gate again starts a fresh N1 phase with the repeat count at zero.
- R8: While the output gate (word 0 bit 30) is clear, `divClk` and `periodStrobe` are low, but counting continues.
- R9: After reset, with both control words zero, all outputs are low.
- R10: With N1=733, N2=732, M1=8 and M2=11, one full pattern of 19 periods spans exactly 13916 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrlWord0 | input | 32 | Divisors, alternation enable and the two gates |
| ctrlWord1 | input | 32 | Repeat counts and bypass enable |
| divClk | output | 1 | Divided clock level |
| periodStrobe | output | 1 | One-cycle pulse on the last cycle of each output period |
| usingSecond | output | 1 | High while the second divisor is active |

## Verification
Several input patterns are used.

- **Small-configuration sweep.** Every combination of divisors 1 to 4 and repeat counts 1 to 3 is run with alternation on. The bench measures each strobe interval and each high time against the expected pattern. This separates off-by-one faults in the divisor and repeat fields, and it catches phase switches that come one period early or late.
- **Single-divisor sweep.** Divisors 1 to 8 are run with junk in the unused fields. This shows whether alternation leaks into plain division.
- **Full-size pattern.** The 733/732/8/11 setting is run over two full patterns and its cycle total is checked.
- **Gate and bypass sequences.** These separate holding from counting. An output gate opened late must give a shortened first period. Reopening the input gate must restart at N1.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int CTRL_W       = 32;
  localparam int DUAL_EN_BIT  = 28;
  localparam int OUT_GATE_BIT = 30;
  localparam int IN_GATE_BIT  = 31;
  localparam int BYPASS_BIT   = 24;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // input gate closed: hold counters at zero
    logic bypass;     // one output period per reference cycle
    logic useSecond;  // select the second divisor
    logic outEnable;  // output gate open (and input gate open)
  } dpCtrl_t;
endpackage

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import frac_div_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrlWord0,
  input  logic [CTRL_W-1:0] ctrlWord1,
  input  logic              periodEnd,
  output dpCtrl_t           dpCtrl,
  output logic [FIELD_W-1:0] n1Field,
  output logic [FIELD_W-1:0] n2Field
);
  localparam int LO_LSB = 0;
  localparam int HI_LSB = FIELD_W;

  logic [FIELD_W-1:0] m1Field, m2Field, repLimit, repCnt;
  logic secondPhase, inGate, outGate, dualEn, bypassEn;

  always_comb begin
    n1Field  = ctrlWord0[LO_LSB +: FIELD_W];
    n2Field  = ctrlWord0[HI_LSB +: FIELD_W];
    m1Field  = ctrlWord1[LO_LSB +: FIELD_W];
    m2Field  = ctrlWord1[HI_LSB +: FIELD_W];
    inGate   = ctrlWord0[IN_GATE_BIT];
    outGate  = ctrlWord0[OUT_GATE_BIT];
    dualEn   = ctrlWord0[DUAL_EN_BIT];
    bypassEn = ctrlWord1[BYPASS_BIT];
    repLimit = secondPhase ? m2Field : m1Field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      repCnt      <= '0;
      secondPhase <= 1'b0;
    end else if (!inGate || bypassEn || !dualEn) begin
      repCnt      <= '0;
      secondPhase <= 1'b0;
    end else if (periodEnd) begin
      if (repCnt >= repLimit) begin
        repCnt      <= '0;
        secondPhase <= ~secondPhase;
      end else begin
        repCnt <= repCnt + 1'b1;
      end
    end
  end

  always_comb begin
    dpCtrl.clear     = ~inGate;
    dpCtrl.bypass    = inGate & bypassEn;
    dpCtrl.useSecond = inGate & dualEn & ~bypassEn & secondPhase;
    dpCtrl.outEnable = inGate & outGate;
  end
endmodule

// File: rtl/frac_div_datapath.sv
module frac_div_datapath
  import frac_div_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpCtrl_t            dpCtrl,
  input  logic [FIELD_W-1:0] n1Field,
  input  logic [FIELD_W-1:0] n2Field,
  output logic               periodEnd,
  output logic               divClk,
  output logic               periodStrobe
);
  localparam int EXT_W = FIELD_W + 1;

  logic [FIELD_W-1:0] cycleCnt, activeField;
  logic [EXT_W-1:0]   highLen;

  always_comb begin
    activeField = dpCtrl.useSecond ? n2Field : n1Field;
    // period is field+1 cycles; high for floor(period/2)
    highLen     = ({1'b0, activeField} + EXT_W'(1)) >> 1;
    periodEnd   = dpCtrl.bypass | (~dpCtrl.clear & (cycleCnt >= activeField));
    periodStrobe = dpCtrl.outEnable & periodEnd;
    divClk       = dpCtrl.outEnable & ~dpCtrl.bypass & ({1'b0, cycleCnt} < highLen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cycleCnt <= '0;
    else if (dpCtrl.clear || dpCtrl.bypass)  cycleCnt <= '0;
    else if (periodEnd)                      cycleCnt <= '0;
    else                                     cycleCnt <= cycleCnt + 1'b1;
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrlWord0,
  input  logic [CTRL_W-1:0] ctrlWord1,
  output logic              divClk,
  output logic              periodStrobe,
  output logic              usingSecond
);
  dpCtrl_t            dpCtrl;
  logic               periodEnd;
  logic [FIELD_W-1:0] n1Field, n2Field;

  frac_div_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrlWord0(ctrlWord0), .ctrlWord1(ctrlWord1),
    .periodEnd(periodEnd), .dpCtrl(dpCtrl), .n1Field(n1Field), .n2Field(n2Field)
  );

  frac_div_datapath #(.FIELD_W(FIELD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl), .n1Field(n1Field), .n2Field(n2Field),
    .periodEnd(periodEnd), .divClk(divClk), .periodStrobe(periodStrobe)
  );

  assign usingSecond = dpCtrl.useSecond;
endmodule

// File: rtl/frac_clk_div_checker.sv
module frac_clk_div_checker
  import frac_div_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrlWord0,
  input logic [CTRL_W-1:0] ctrlWord1,
  input logic              divClk,
  input logic              periodStrobe,
  input logic              usingSecond,
  input logic              periodEnd
);
  // R8: closed output gate silences both outputs
  assert_out_gate_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlWord0[OUT_GATE_BIT] |-> (!divClk && !periodStrobe));

  // R7: closed input gate holds everything low
  assert_in_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlWord0[IN_GATE_BIT] |-> (!usingSecond && !periodStrobe && !divClk));

  // R7: reopening the input gate starts on the first divisor
  assert_restart_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrlWord0[IN_GATE_BIT]) |-> !usingSecond);

  // R3: no second divisor in single mode
  assert_single_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlWord0[DUAL_EN_BIT] |-> !usingSecond);

  // R2: the divisor switches only after a period boundary
  assert_switch_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ctrlWord0) && $stable(ctrlWord1) && ctrlWord0[IN_GATE_BIT]
     && (usingSecond != $past(usingSecond))) |-> $past(periodEnd));

  // R6: bypass gives a strobe each cycle and no clock level
  assert_bypass_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWord0[IN_GATE_BIT] && ctrlWord0[OUT_GATE_BIT] && ctrlWord1[BYPASS_BIT])
    |-> (periodStrobe && !divClk));
endmodule

bind frac_clk_div frac_clk_div_checker u_frac_clk_div_checker (
  .clk(clk), .rst_n(rst_n), .ctrlWord0(ctrlWord0), .ctrlWord1(ctrlWord1),
  .divClk(divClk), .periodStrobe(periodStrobe), .usingSecond(usingSecond),
  .periodEnd(periodEnd)
);

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] w0 = '0;
  logic [31:0] w1 = '0;
  logic divClk, periodStrobe, usingSecond;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frac_clk_div i_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .ctrlWord0(w0), .ctrlWord1(w1),
    .divClk(divClk), .periodStrobe(periodStrobe), .usingSecond(usingSecond)
  );

  function automatic logic [31:0] mk0(int n1, int n2, bit dual, bit og, bit ig);
    logic [11:0] a = 12'(n1 - 1);
    logic [11:0] b = 12'(n2 - 1);
    return {ig, og, 1'b0, dual, 4'b0, b, a};
  endfunction

  function automatic logic [31:0] mk1(int m1, int m2, bit byp);
    logic [11:0] a = 12'(m1 - 1);
    logic [11:0] b = 12'(m2 - 1);
    return {7'b0, byp, b, a};
  endfunction

  task automatic checkEq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // load words with both gates closed, then open both
  task automatic startCfg(logic [31:0] v0, logic [31:0] v1);
    w0 = v0 & 32'h3fff_ffff;
    w1 = v1;
    step();
    w0 = v0 | 32'hc000_0000;
    #1;
  endtask

  // sample now and after each edge; check every strobe interval
  task automatic expectSeq(int n1, int n2, int m1, int m2, bit dual, int periods,
                           string req, output int sum);
    int c = 0;
    int hi = 0;
    int idx = 0;
    sum = 0;
    while (idx < periods) begin
      int pos = dual ? idx % (m1 + m2) : 0;
      int expN = (dual && pos >= m1) ? n2 : n1;
      c++;
      if (divClk) hi++;
      if (periodStrobe) begin
        checkEq({req, " period"}, c, expN);
        checkEq("R5 high time", hi, expN / 2);
        checkEq("R4 second flag", int'(usingSecond), int'(dual && pos >= m1));
        sum += c;
        idx++;
        c = 0;
        hi = 0;
      end else if (c > expN + 1) begin
        checkEq({req, " missing strobe"}, c, expN);
        idx = periods;
      end
      if (idx < periods) step();
    end
  endtask

  initial begin
    int s;
    int k;
    // R9: reset state
    repeat (3) @(posedge clk);
    #2;
    checkEq("R9 divClk", int'(divClk), 0);
    checkEq("R9 strobe", int'(periodStrobe), 0);
    checkEq("R9 second", int'(usingSecond), 0);
    rst_n = 1'b1;
    step();

    // R10 / R2: full-size pattern, two rounds
    startCfg(mk0(733, 732, 1, 1, 1), mk1(8, 11, 0));
    expectSeq(733, 732, 8, 11, 1, 19, "R10", s);
    checkEq("R10 pattern total", s, 13916);
    step();
    expectSeq(733, 732, 8, 11, 1, 19, "R2", s);
    checkEq("R10 second pattern total", s, 13916);

    // R2: sweep of small configurations
    for (int a = 1; a <= 4; a++)
      for (int b = 1; b <= 4; b++)
        for (int p = 1; p <= 3; p++)
          for (int q = 1; q <= 3; q++) begin
            startCfg(mk0(a, b, 1, 1, 1), mk1(p, q, 0));
            expectSeq(a, b, p, q, 1, 2 * (p + q), "R2", s);
          end

    // R1 / R3: single divisor with junk in the other fields
    for (int a = 1; a <= 8; a++) begin
      startCfg(mk0(a, 9 - a + 3, 0, 1, 1), mk1(a + 1, 2, 0));
      expectSeq(a, 1, 1, 1, 0, 6, "R1", s);
      checkEq("R3 single total", s, 6 * a);
    end

    // R6: bypass, with alternation also set
    startCfg(mk0(5, 6, 1, 1, 1), mk1(2, 2, 1));
    k = 0;
    for (int i = 0; i < 20; i++) begin
      if (periodStrobe && !divClk && !usingSecond) k++;
      step();
    end
    checkEq("R6 bypass strobes", k, 20);

    // R8: output gate opened late; counting ran in the meantime
    w0 = mk0(10, 1, 0, 0, 0);
    w1 = mk1(1, 1, 0);
    step();
    w0 = mk0(10, 1, 0, 0, 1);
    #1;
    k = 0;
    for (int i = 0; i < 23; i++) begin
      if (periodStrobe || divClk) k++;
      if (i < 22) step();
    end
    checkEq("R8 quiet while gated", k, 0);
    w0 = mk0(10, 1, 0, 1, 1);
    #1;
    k = 0;
    while (!periodStrobe && k < 20) begin
      k++;
      step();
    end
    checkEq("R8 first interval after late gate", k + 1, 8);
    step();
    expectSeq(10, 1, 1, 1, 0, 2, "R8", s);

    // R7: stop in the middle of the second phase, then restart
    startCfg(mk0(3, 5, 1, 1, 1), mk1(2, 2, 0));
    expectSeq(3, 5, 2, 2, 1, 3, "R7", s);
    step();
    checkEq("R7 second phase before stop", int'(usingSecond), 1);
    w0 = mk0(3, 5, 1, 1, 0);
    #1;
    k = 0;
    for (int i = 0; i < 5; i++) begin
      if (periodStrobe || divClk || usingSecond) k++;
      step();
    end
    checkEq("R7 outputs low while held", k, 0);
    w0 = mk0(3, 5, 1, 1, 1);
    #1;
    expectSeq(3, 5, 2, 2, 1, 8, "R7 restart", s);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule